// File: doc/BRIEF.md
# Instruction Prefetch Queue with Branch Flush

This block fetches instruction bytes ahead of an execution unit and holds them in a small byte queue. It forms each 20-bit fetch address from a 16-bit code segment and a 16-bit fetch offset. It issues byte reads on a request/response memory port and hands the buffered bytes to the consumer through a valid/ready handshake. Fetching runs on its own while the consumer works, so fetch and execute overlap. When the queue fills, the memory port stays idle until a byte is taken.

A jump input carries a new segment and offset. In one cycle the jump empties the queue and reloads the fetch pointer. If a read is still outstanding, its response is dropped. The consumer then waits at least one fetch latency for the first byte from the new target.

The fetch controller has three states. FS_ISSUE may raise a request. FS_WAIT waits for the response to an accepted request. FS_DRAIN waits for, and then discards, a response whose request came before a jump. The transitions are:
- FS_ISSUE to FS_WAIT on a request handshake.
- FS_WAIT to FS_ISSUE when a response arrives. The byte is pushed unless a jump happens in the same cycle.
- FS_WAIT to FS_DRAIN on a jump with no response in that cycle.
- FS_DRAIN to FS_ISSUE when the stale response arrives.
- A jump seen in FS_ISSUE keeps the controller in FS_ISSUE and suppresses the request for that cycle.

Top module: `pfq_prefetch_unit`

## Requirements
- R1: Reset (synchronous, rst_n low) empties the queue, so q_valid is 0. The first request after reset goes to address (rst_seg << 4) + rst_off; segment 2500h with offset 95F3h gives 2E5F3h.
- R2: Every request address is (segment << 4) + offset, truncated to 20 bits. Segment FFFFh with offset 0012h gives 00002h.
- R3: The offset rises by one for each accepted request and wraps from FFFFh to 0000h. The segment does not change.
- R4: q_valid is 1 whenever the queue holds a byte. Bytes reach q_data in the order their addresses were fetched, and a byte is removed when q_valid and q_ready are both 1.
- R5: The queue depth is 6 when WIDE_BUS is 1 (the default) and 4 when it is 0. With no byte consumed after reset, exactly that many requests are issued.
- R6: While the queue is full, mem_req_valid stays 0. After one byte is consumed, exactly one more request is issued.
- R7: A push from a response and a pop by the consumer may happen in the same cycle without losing or duplicating a byte.
- R8: The cycle after jump_valid is 1, q_valid is 0 and all earlier bytes are gone. The next request goes to the jump target.
- R9: A response to a request accepted before a jump is never written into the queue. The first byte delivered after a jump comes from the target address.
- R10: At most one request is outstanding. No new request is accepted before the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_seg | input | 16 | Code segment loaded at reset |
| rst_off | input | 16 | Fetch offset loaded at reset |
| jump_valid | input | 1 | Jump strobe: flush and redirect |
| jump_seg | input | 16 | Target segment of a jump |
| jump_off | input | 16 | Target offset of a jump |
| mem_req_valid | output | 1 | Byte read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 20 | Physical byte address of the request |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 8 | Read data byte |
| q_valid | output | 1 | A buffered byte is available |
| q_ready | input | 1 | Consumer takes the byte |
| q_data | output | 8 | Oldest buffered byte |

## Verification
The main function is tried under four input patterns, and each one separates a different kind of fault.

- A consumer that never takes bytes shows whether filling stops at the configured depth. It also shows whether fetching resumes after exactly one pop.
- A consumer that is always ready, with a memory that answers at once, forces pushes and pops into the same cycle. The byte-order scoreboard then catches a lost or repeated byte.
- A jump taken while a slow response is outstanding shows whether the stale byte is dropped and whether fetching restarts at the target.
- Targets near the top of the offset range and the top of the 20-bit space separate a correct wrap of the offset and truncation of the address from a carry into the segment.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    localparam int SEG_W     = 16;
    localparam int OFF_W     = 16;
    localparam int SEG_SHIFT = 4;
    localparam int PHYS_W    = 20;
    localparam int BYTE_W    = 8;

    typedef enum logic [1:0] {
        FS_ISSUE = 2'd0,
        FS_WAIT  = 2'd1,
        FS_DRAIN = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/pfq_addr_gen.sv
module pfq_addr_gen
    import pfq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEG_W-1:0]  rst_seg,
    input  logic [OFF_W-1:0]  rst_off,
    input  logic              load,
    input  logic [SEG_W-1:0]  load_seg,
    input  logic [OFF_W-1:0]  load_off,
    input  logic              advance,
    output logic [PHYS_W-1:0] phys_addr
);
    logic [SEG_W-1:0] seg_q;
    logic [OFF_W-1:0] off_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= rst_seg;
            off_q <= rst_off;
        end else if (load) begin
            seg_q <= load_seg;
            off_q <= load_off;
        end else if (advance) begin
            off_q <= off_q + 1'b1;
        end
    end

    assign phys_addr = PHYS_W'({seg_q, {SEG_SHIFT{1'b0}}}) + PHYS_W'(off_q);

    // R3
    offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> (off_q == $past(off_q) + 1'b1) && $stable(seg_q));
endmodule

// File: rtl/pfq_byte_queue.sv
module pfq_byte_queue #(
    parameter int DEPTH  = 6,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       pop,
    output logic [DATA_W-1:0]          pop_data,
    output logic                       not_empty,
    output logic                       full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && !flush;
    assign do_pop  = pop && !flush && (count_q != '0);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && (wr_ptr_q == PTR_W'(g)))
                slot_q[g] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= bump(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
            unique case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign pop_data  = slot_q[rd_ptr_q];
    assign not_empty = (count_q != '0);
    assign full      = (count_q == CNT_W'(DEPTH));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R7
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !flush && not_empty) |=> $stable(count_q));
endmodule

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl
    import pfq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic jump,
    input  logic full,
    input  logic req_ready,
    input  logic rsp_valid,
    output logic req_valid,
    output logic push
);
    fetch_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_ISSUE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_ISSUE: if (req_valid && req_ready) state_d = FS_WAIT;
            FS_WAIT:  begin
                if (rsp_valid)  state_d = FS_ISSUE;
                else if (jump)  state_d = FS_DRAIN;
            end
            FS_DRAIN: if (rsp_valid) state_d = FS_ISSUE;
            default:  state_d = FS_ISSUE;
        endcase
    end

    always_comb begin
        req_valid = 1'b0;
        push      = 1'b0;
        unique case (state_q)
            FS_ISSUE: req_valid = !jump && !full;
            FS_WAIT:  push      = rsp_valid && !jump;
            FS_DRAIN: push      = 1'b0;
            default:  req_valid = 1'b0;
        endcase
    end

    // R10
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid);
    // R9
    drain_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_WAIT && jump && !rsp_valid) |=> !push);
endmodule

// File: rtl/pfq_prefetch_unit.sv
module pfq_prefetch_unit
    import pfq_pkg::*;
#(
    parameter bit WIDE_BUS     = 1'b1,
    parameter int WIDE_DEPTH   = 6,
    parameter int NARROW_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEG_W-1:0]  rst_seg,
    input  logic [OFF_W-1:0]  rst_off,
    input  logic              jump_valid,
    input  logic [SEG_W-1:0]  jump_seg,
    input  logic [OFF_W-1:0]  jump_off,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PHYS_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [BYTE_W-1:0] mem_rsp_data,
    output logic              q_valid,
    input  logic              q_ready,
    output logic [BYTE_W-1:0] q_data
);
    localparam int DEPTH = WIDE_BUS ? WIDE_DEPTH : NARROW_DEPTH;

    logic full, push, req_fire;

    assign req_fire = mem_req_valid && mem_req_ready;

    pfq_addr_gen u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_seg   (rst_seg),
        .rst_off   (rst_off),
        .load      (jump_valid),
        .load_seg  (jump_seg),
        .load_off  (jump_off),
        .advance   (req_fire),
        .phys_addr (mem_req_addr)
    );

    pfq_fetch_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .jump      (jump_valid),
        .full      (full),
        .req_ready (mem_req_ready),
        .rsp_valid (mem_rsp_valid),
        .req_valid (mem_req_valid),
        .push      (push)
    );

    pfq_byte_queue #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (jump_valid),
        .push      (push),
        .push_data (mem_rsp_data),
        .pop       (q_valid && q_ready),
        .pop_data  (q_data),
        .not_empty (q_valid),
        .full      (full)
    );

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_valid |=> !q_valid);
endmodule

// File: tb/pfq_prefetch_unit_bench.sv
module pfq_prefetch_unit_bench;
    localparam int DEPTH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rst_seg = 16'h2500, rst_off = 16'h95F3;
    logic        jump_valid = 1'b0;
    logic [15:0] jump_seg = '0, jump_off = '0;
    logic        mem_req_valid, mem_req_ready = 1'b0;
    logic [19:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_data = '0;
    logic        q_valid, q_ready = 1'b0;
    logic [7:0]  q_data;

    int checks = 0, fails = 0;
    int lat = 0, outstanding = 0, req_count = 0, pop_count = 0;
    bit overlap = 0, hs_seen = 0, pend = 0, after_jump = 0, got_first = 0;
    logic [19:0] hs_addr, pend_addr, first_req;
    int pend_cnt = 0;
    logic [7:0] first_pop;
    logic [15:0] exp_seg, exp_off;
    logic [7:0] exp_q[$];
    logic [19:0] jump_reqs[$];
    int req_high = 0;

    always #4 clk = ~clk;

    pfq_prefetch_unit u_pfq_prefetch_unit (
        .clk(clk), .rst_n(rst_n), .rst_seg(rst_seg), .rst_off(rst_off),
        .jump_valid(jump_valid), .jump_seg(jump_seg), .jump_off(jump_off),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .q_valid(q_valid), .q_ready(q_ready),
        .q_data(q_data)
    );

    function automatic logic [7:0] pat(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]};
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // driver side of the scoreboard: expected byte stream for a target
    task automatic push_run(input logic [15:0] s, input logic [15:0] o, input int n);
        for (int k = 0; k < n; k++) begin
            logic [15:0] ok;
            ok = o + 16'(k);
            exp_q.push_back(pat(phys(s, ok)));
        end
    endtask

    task automatic do_jump(input logic [15:0] s, input logic [15:0] o);
        @(posedge clk); #1;
        q_ready = 1'b0;
        jump_valid = 1'b1; jump_seg = s; jump_off = o;
        exp_q.delete();
        push_run(s, o, 256);
        exp_seg = s; exp_off = o;
        jump_reqs.delete();
        after_jump = 1; got_first = 0;
        @(posedge clk); #1;
        jump_valid = 1'b0;
    endtask

    // memory model
    always @(posedge clk) begin
        #1;
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (pend_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data = pat(pend_addr);
                pend = 0;
            end else pend_cnt--;
        end
        if (hs_seen) begin
            pend = 1; pend_addr = hs_addr; pend_cnt = lat; hs_seen = 0;
        end
    end

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req_valid) req_high++;
            if (mem_rsp_valid) outstanding--;
            if (mem_req_valid && mem_req_ready) begin
                check("R10 outstanding", 32'(outstanding), 32'd0);
                outstanding++;
                if (req_count == 0) first_req = mem_req_addr;
                req_count++;
                check("R2 request address", 32'(mem_req_addr), 32'(phys(exp_seg, exp_off)));
                exp_off = exp_off + 16'd1;
                jump_reqs.push_back(mem_req_addr);
                hs_seen = 1; hs_addr = mem_req_addr;
            end
            if (q_valid && q_ready) begin
                logic [7:0] e;
                e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'hxx;
                check("R4 byte order", 32'(q_data), 32'(e));
                pop_count++;
                if (mem_rsp_valid) overlap = 1;
                if (after_jump && !got_first) begin first_pop = q_data; got_first = 1; end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        exp_seg = rst_seg; exp_off = rst_off;
        push_run(rst_seg, rst_off, 256);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 empty after reset", 32'(q_valid), 32'd0);
        @(posedge clk); #1 mem_req_ready = 1'b1;

        // fill with no consumer
        repeat (60) @(posedge clk);
        @(negedge clk);
        check("R1 first address", 32'(first_req), 32'h2E5F3);
        check("R5 requests at full", 32'(req_count), 32'(DEPTH));
        check("R4 valid when non-empty", 32'(q_valid), 32'd1);
        req_high = 0;
        repeat (10) @(negedge clk);
        check("R6 idle while full", 32'(req_high), 32'd0);

        // one pop releases one fetch
        @(posedge clk); #1 q_ready = 1'b1;
        @(posedge clk); #1 q_ready = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R6 one refetch", 32'(req_count), 32'(DEPTH + 1));
        check("R6 one pop", 32'(pop_count), 32'd1);

        // streaming: push and pop overlap
        @(posedge clk); #1 q_ready = 1'b1;
        repeat (100) @(posedge clk);
        @(negedge clk);
        check("R7 overlap seen", 32'(overlap), 32'd1);
        check("R4 stream progress", 32'(pop_count > 25), 32'd1);

        // slow memory, jump with a read in flight, target near offset wrap
        lat = 4;
        repeat (30) @(posedge clk);
        while (!pend) @(posedge clk);
        do_jump(16'h1234, 16'hFFFE);
        @(negedge clk);
        check("R8 empty after jump", 32'(q_valid), 32'd0);
        @(posedge clk); #1 q_ready = 1'b1;
        repeat (80) @(posedge clk);
        @(negedge clk);
        check("R9 first byte after jump", 32'(first_pop), 32'(pat(20'h2233E)));
        check("R8 first target request", 32'(jump_reqs[0]), 32'h2233E);
        check("R3 offset wrap", 32'(jump_reqs[2]), 32'h12340);

        // 20-bit truncation
        lat = 0;
        do_jump(16'hFFFF, 16'h0012);
        @(posedge clk); #1 q_ready = 1'b1;
        repeat (40) @(posedge clk);
        @(negedge clk);
        check("R2 truncated address", 32'(jump_reqs[0]), 32'h00002);
        check("R9 first byte truncated target", 32'(first_pop), 32'(pat(20'h00002)));

        // back-to-back jumps with slow memory
        lat = 3;
        do_jump(16'h0100, 16'h0000);
        do_jump(16'h0200, 16'h0010);
        @(posedge clk); #1 q_ready = 1'b1;
        repeat (60) @(posedge clk);
        @(negedge clk);
        check("R9 second jump wins", 32'(first_pop), 32'(pat(20'h02010)));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule